// File: doc/BRIEF.md
# Protection Page Register File with Sticky Locks

This block keeps the 16-byte access-control page and the 16-byte identification page of a protected serial memory. Both pages sit behind one byte-wide request port. Each request carries a word address, a read/write flag, write data and a flag that marks a byte that is not the first of its transfer. One cycle later the block returns an acknowledge or refusal, together with the read data.

The control page holds a two-bit protection code for each memory block and one for the page region. It also holds a page write-enable byte, a detect-emulation byte, three general-purpose bytes and two fixed bytes. Each lockable byte has a lock bit in its bit 7. The lock bits live in volatile flops. They start at 1 after reset and are set to 1 again while the protect-reset input is low. Software can only clear them, and a cleared lock freezes its whole byte.

All other fields stand in for non-volatile storage, so they keep their values through protect-reset. The protection codes, the page write-enable byte and the page-region code are driven out as ports for a separate permission checker.

Top module: `ppr_regfile`

## Requirements
- R1: Every cycle with `req_valid` high is followed, one cycle later, by `rsp_valid` high. A cycle without a request is followed by `rsp_valid` low. `rsp_rdata` is 00h for a write and for any refused request.
- R2: The lock bit of bytes 0 to 8 is bit 7 of the byte. All nine lock bits read 1 after `rst`, and they are 1 one cycle after any cycle in which `prot_n` is low. A write clears a lock bit when write-data bit 7 is 0. No write sets a lock bit.
- R3: A write to one of bytes 0 to 8 while that byte's lock bit is 0 is acknowledged and leaves the byte unchanged.
- R4: Bytes 0 to 7 read as {lock, 0, RF[1:0], 00, code[1:0]}. Byte 8 reads as {lock, 00000, code[1:0]}. `blk_code[2i+1:2i]` is the code of byte i, and `page_code` is the code held in byte 8.
- R5: Byte 14 always reads FFh and byte 15 always reads 10h. Writes to either byte are acknowledged and change nothing.
- R6: Byte 10 reads as {enable, detect, 000000}. Bit 0 always reads 0. The enable bit is writable. The detect bit is read-only. After `rst` or `prot_n` low, enable is 0 and detect is 1. Writing enable as 1 clears detect, and detect stays 0 until the next reinitialisation.
- R7: A request with `req_cont` high, or with `req_addr[7:5]` not 000, is refused (`rsp_ack` 0) and changes no state.
- R8: Byte 9 and bytes 11 to 13 are plain read/write bytes, and byte 9 drives `page_wen`. Addresses 10h to 1Fh read and write the identification page.
- R9: After `rst`, the codes and RF fields are 11, and bytes 9, 11, 12 and 13 are FFh. All stored fields keep their values through `prot_n` low.
- R10: While `prot_n` is low, every request is refused and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| prot_n | input | 1 | Active-low protect reset; reinitialises lock and detect bits |
| req_valid | input | 1 | Request strobe, one byte per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cont | input | 1 | 1 = byte is not the first of its transfer |
| req_addr | input | 8 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_ack | output | 1 | 1 = acknowledged, 0 = refused |
| rsp_rdata | output | 8 | Read data |
| blk_code | output | 16 | Two-bit protection code per block |
| page_code | output | 2 | Protection code of the page region |
| page_wen | output | 8 | Page write-enable byte |

## Verification
The assertions assume that `rst` is high at time zero and that `req_cont` is meaningful only when `req_valid` is high. They also assume at most one request per cycle, so a read and a write never compete for a byte. The bench drives requests at the falling edge, one per cycle or with gaps, and toggles `prot_n` only between requests. Because identification-page bytes have no reset value, the bench writes every one of them before any random read can reach them.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FIXED_ONES = 8'hFF;
  localparam logic [BYTE_W-1:0] REV_VALUE  = 8'h10;
  typedef logic [1:0] prot_code_t;
endpackage

// File: rtl/ppr_lock_bank.sv
module ppr_lock_bank #(
  parameter int NLOCK = 9,
  parameter int IW    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             prot_n,
  input  logic             lock_wr,
  input  logic [IW-1:0]    idx,
  input  logic             wbit7,
  input  logic             det_wr,
  output logic [NLOCK-1:0] sticky,
  output logic             det_en,
  output logic             det_flag
);
  logic reinit;
  assign reinit = rst || !prot_n;

  for (genvar i = 0; i < NLOCK; i++) begin : g_lock
    logic s_q;
    always_ff @(posedge clk) begin
      if (reinit) s_q <= 1'b1;
      else if (lock_wr && idx == IW'(i) && s_q && !wbit7) s_q <= 1'b0;
    end
    assign sticky[i] = s_q;
  end

  always_ff @(posedge clk) begin
    if (reinit) begin
      det_en   <= 1'b0;
      det_flag <= 1'b1;
    end else if (det_wr) begin
      det_en <= wbit7;
      if (wbit7) det_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/ppr_ctrl_store.sv
module ppr_ctrl_store #(
  parameter int NBLK = 8,
  parameter int NRES = 3,
  parameter int IW   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [IW-1:0]     idx,
  input  logic [7:0]        wdata,
  input  logic              open,
  output logic [2*NBLK-1:0] blk_code,
  output logic [2*NBLK-1:0] blk_rf,
  output logic [1:0]        page_code,
  output logic [7:0]        page_wen,
  output logic [8*NRES-1:0] res_flat
);
  for (genvar b = 0; b < NBLK; b++) begin : g_blk
    logic [1:0] code_q, rf_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= 2'b11;
        rf_q   <= 2'b11;
      end else if (wr && open && idx == IW'(b)) begin
        code_q <= wdata[1:0];
        rf_q   <= wdata[5:4];
      end
    end
    assign blk_code[2*b +: 2] = code_q;
    assign blk_rf[2*b +: 2]   = rf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) page_code <= 2'b11;
    else if (wr && open && idx == IW'(NBLK)) page_code <= wdata[1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) page_wen <= '1;
    else if (wr && idx == IW'(NBLK+1)) page_wen <= wdata;
  end

  for (genvar r = 0; r < NRES; r++) begin : g_res
    logic [7:0] res_q;
    always_ff @(posedge clk) begin
      if (rst) res_q <= '1;
      else if (wr && idx == IW'(NBLK+3+r)) res_q <= wdata;
    end
    assign res_flat[8*r +: 8] = res_q;
  end
endmodule

// File: rtl/ppr_id_ram.sv
module ppr_id_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/ppr_regfile.sv
module ppr_regfile
  import ppr_pkg::*;
#(
  parameter int NBLK = 8,
  parameter int AW   = 8,
  parameter int PB   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prot_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_cont,
  input  logic [AW-1:0]     req_addr,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  output logic              rsp_ack,
  output logic [7:0]        rsp_rdata,
  output logic [2*NBLK-1:0] blk_code,
  output logic [1:0]        page_code,
  output logic [7:0]        page_wen
);
  localparam int IW    = $clog2(PB);
  localparam int NLOCK = NBLK + 1;
  localparam int NRES  = PB - NBLK - 5;
  localparam logic [IW-1:0] I_PAGE = IW'(NBLK);
  localparam logic [IW-1:0] I_WEN  = IW'(NBLK + 1);
  localparam logic [IW-1:0] I_DET  = IW'(NBLK + 2);
  localparam logic [IW-1:0] I_ONES = IW'(PB - 2);
  localparam logic [IW-1:0] I_REV  = IW'(PB - 1);

  logic [IW-1:0]     idx;
  logic              id_sel, good, ctl_wr, id_wr, lock_open;
  logic [NLOCK-1:0]  sticky;
  logic              det_en, det_flag;
  logic [2*NBLK-1:0] blk_rf;
  logic [8*NRES-1:0] res_flat;
  logic [7:0]        ctl_rd, ctl_q, id_rd;
  logic              from_id_q;

  assign idx    = req_addr[IW-1:0];
  assign id_sel = req_addr[IW];
  assign good   = req_valid && prot_n && !req_cont && (req_addr[AW-1:IW+1] == '0);
  assign ctl_wr = good && req_write && !id_sel;
  assign id_wr  = good && req_write && id_sel;

  always_comb begin
    lock_open = 1'b1;
    for (int k = 0; k < NLOCK; k++)
      if (idx == IW'(k)) lock_open = sticky[k];
  end

  ppr_lock_bank #(.NLOCK(NLOCK), .IW(IW)) u_locks (
    .clk(clk), .rst(rst), .prot_n(prot_n), .lock_wr(ctl_wr), .idx(idx),
    .wbit7(req_wdata[7]), .det_wr(ctl_wr && idx == I_DET),
    .sticky(sticky), .det_en(det_en), .det_flag(det_flag)
  );

  ppr_ctrl_store #(.NBLK(NBLK), .NRES(NRES), .IW(IW)) u_store (
    .clk(clk), .rst(rst), .wr(ctl_wr), .idx(idx), .wdata(req_wdata),
    .open(lock_open), .blk_code(blk_code), .blk_rf(blk_rf),
    .page_code(page_code), .page_wen(page_wen), .res_flat(res_flat)
  );

  ppr_id_ram #(.DEPTH(PB), .W(8)) u_id (
    .clk(clk), .we(id_wr), .addr(idx), .wdata(req_wdata), .rdata(id_rd)
  );

  always_comb begin
    ctl_rd = '0;
    for (int k = 0; k < NBLK; k++)
      if (idx == IW'(k))
        ctl_rd = {sticky[k], 1'b0, blk_rf[2*k +: 2], 2'b00, blk_code[2*k +: 2]};
    for (int r = 0; r < NRES; r++)
      if (idx == IW'(NBLK + 3 + r)) ctl_rd = res_flat[8*r +: 8];
    if (idx == I_PAGE) ctl_rd = {sticky[NBLK], 5'b00000, page_code};
    if (idx == I_WEN)  ctl_rd = page_wen;
    if (idx == I_DET)  ctl_rd = {det_en, det_flag, 6'b000000};
    if (idx == I_ONES) ctl_rd = FIXED_ONES;
    if (idx == I_REV)  ctl_rd = REV_VALUE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_ack   <= 1'b0;
      from_id_q <= 1'b0;
      ctl_q     <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_ack   <= good;
      from_id_q <= good && !req_write && id_sel;
      ctl_q     <= (good && !req_write && !id_sel) ? ctl_rd : '0;
    end
  end

  assign rsp_rdata = from_id_q ? id_rd : ctl_q;
endmodule

// File: rtl/ppr_regfile_chk.sv
module ppr_regfile_chk #(
  parameter int NBLK = 8,
  parameter int AW   = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              prot_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_cont,
  input logic [AW-1:0]     req_addr,
  input logic              rsp_valid,
  input logic              rsp_ack,
  input logic [7:0]        rsp_rdata,
  input logic [2*NBLK-1:0] blk_code,
  input logic [1:0]        page_code,
  input logic [NBLK:0]     sticky
);
  logic plain_rd;
  assign plain_rd = req_valid && !req_write && !req_cont && prot_n;

  p_rsp_follows_r1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  p_rsp_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  p_wr_zero_data_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |=> (rsp_rdata == 8'h00));
  p_lock_reinit_r2: assert property (@(posedge clk) disable iff (rst)
    !prot_n |=> (&sticky));
  p_lock_no_rise_r2: assert property (@(posedge clk) disable iff (rst)
    prot_n |=> ((sticky & ~$past(sticky)) == '0));
  p_page_frozen_r3: assert property (@(posedge clk) disable iff (rst)
    (prot_n && !sticky[NBLK]) |=> $stable(page_code));
  for (genvar b = 0; b < NBLK; b++) begin : g_frz
    p_code_frozen_r3: assert property (@(posedge clk) disable iff (rst)
      (prot_n && !sticky[b]) |=> $stable(blk_code[2*b +: 2]));
  end
  p_ones_byte_r5: assert property (@(posedge clk) disable iff (rst)
    (plain_rd && req_addr == AW'(14)) |=> (rsp_rdata == 8'hFF));
  p_rev_byte_r5: assert property (@(posedge clk) disable iff (rst)
    (plain_rd && req_addr == AW'(15)) |=> (rsp_rdata == 8'h10));
  p_tamper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (plain_rd && req_addr == AW'(10)) |=> (rsp_rdata[5:0] == 6'd0));
  p_cont_nack_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_cont) |=> !rsp_ack);
  p_high_addr_nack_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr[AW-1:5] != '0) |=> !rsp_ack);
  p_prot_nack_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !prot_n) |=> !rsp_ack);
endmodule

bind ppr_regfile ppr_regfile_chk #(.NBLK(NBLK), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .prot_n(prot_n), .req_valid(req_valid),
  .req_write(req_write), .req_cont(req_cont), .req_addr(req_addr),
  .rsp_valid(rsp_valid), .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
  .blk_code(blk_code), .page_code(page_code), .sticky(sticky)
);

// File: tb/sim_ppr_regfile.sv
module sim_ppr_regfile;
  logic clk = 1'b0, rst = 1'b1, prot_n = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_cont = 1'b0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic rsp_valid, rsp_ack;
  logic [7:0] rsp_rdata, page_wen;
  logic [15:0] blk_code;
  logic [1:0] page_code;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  string tag = "R1";

  always #2 clk = ~clk;

  ppr_regfile u0 (.*);

  // behavioural reference
  bit [7:0] m_ctl [9];
  bit       m_sb  [9];
  bit [7:0] m_wen, m_res [3], m_id [16];
  bit       m_de, m_dc;
  bit       e_valid, e_ack;
  bit [7:0] e_rd;

  function automatic bit [7:0] mread(bit [4:0] a);
    if (a >= 16) return m_id[a - 16];
    if (a < 9)  return {m_sb[a], 7'b0} | m_ctl[a];
    case (a)
      9: return m_wen;
      10: return {m_de, m_dc, 6'b0};
      14: return 8'hFF;
      15: return 8'h10;
      default: return m_res[a - 11];
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 9; i++) begin
        m_ctl[i] = (i < 8) ? 8'h33 : 8'h03;
        m_sb[i] = 1;
      end
      m_wen = 8'hFF;
      for (int i = 0; i < 3; i++) m_res[i] = 8'hFF;
      m_de = 0; m_dc = 1;
      e_valid = 0; e_ack = 0; e_rd = 0;
    end else begin
      bit good;
      bit [4:0] a;
      a = req_addr[4:0];
      good = req_valid && prot_n && !req_cont && req_addr[7:5] == 0;
      e_valid = req_valid;
      e_ack = good;
      e_rd = (good && !req_write) ? mread(a) : 8'h00;
      if (!prot_n) begin
        for (int i = 0; i < 9; i++) m_sb[i] = 1;
        m_de = 0; m_dc = 1;
      end else if (good && req_write) begin
        if (a >= 16) m_id[a - 16] = req_wdata;
        else if (a < 9) begin
          if (m_sb[a]) begin
            m_ctl[a] = req_wdata & ((a < 8) ? 8'h33 : 8'h03);
            m_sb[a] = req_wdata[7];
          end
        end else if (a == 9) m_wen = req_wdata;
        else if (a == 10) begin
          m_de = req_wdata[7];
          if (req_wdata[7]) m_dc = 0;
        end else if (a >= 11 && a <= 13) m_res[a - 11] = req_wdata;
      end
    end
  end

  function automatic bit [15:0] m_codes();
    bit [15:0] c;
    for (int i = 0; i < 8; i++) c[2*i +: 2] = m_ctl[i][1:0];
    return c;
  endfunction

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done)
      chk({tag, " model"},
          {rsp_valid, rsp_ack, rsp_rdata, blk_code, page_code, page_wen},
          {e_valid, e_ack, e_rd, m_codes(), m_ctl[8][1:0], m_wen});
  end

  task automatic do_req(input bit we, input bit cont, input logic [7:0] a,
                        input logic [7:0] wd, output bit ack, output logic [7:0] rd);
    @(negedge clk);
    req_valid = 1; req_write = we; req_cont = cont; req_addr = a; req_wdata = wd;
    @(negedge clk);
    ack = rsp_ack; rd = rsp_rdata;
    req_valid = 0; req_cont = 0;
  endtask

  task automatic prot_pulse();
    @(negedge clk); prot_n = 0;
    @(negedge clk);
    @(negedge clk); prot_n = 1;
  endtask

  initial begin
    bit ack;
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    rst = 0;

    tag = "R2";
    do_req(0, 0, 8'h00, 0, ack, rd); chk("R2 R4 reset byte0", rd, 8'hB3);
    do_req(0, 0, 8'h08, 0, ack, rd); chk("R4 reset byte8", rd, 8'h83);
    chk("R9 reset codes", {blk_code, page_code, page_wen}, {16'hFFFF, 2'b11, 8'hFF});
    tag = "R6";
    do_req(0, 0, 8'h0A, 0, ack, rd); chk("R6 reset detect byte", rd, 8'h40);
    tag = "R5";
    do_req(0, 0, 8'h0E, 0, ack, rd); chk("R5 byte14", rd, 8'hFF);
    do_req(0, 0, 8'h0F, 0, ack, rd); chk("R5 byte15", rd, 8'h10);
    do_req(1, 0, 8'h0E, 8'h00, ack, rd); chk("R5 byte14 write ack", ack, 1);
    chk("R1 write rdata zero", rd, 8'h00);
    do_req(0, 0, 8'h0E, 0, ack, rd); chk("R5 byte14 unchanged", rd, 8'hFF);
    do_req(1, 0, 8'h0F, 8'h55, ack, rd);
    do_req(0, 0, 8'h0F, 0, ack, rd); chk("R5 byte15 unchanged", rd, 8'h10);

    tag = "R4";
    do_req(1, 0, 8'h02, 8'h62, ack, rd);
    do_req(0, 0, 8'h02, 0, ack, rd); chk("R4 R2 byte2 fields", rd, 8'h22);
    chk("R4 exported code2", blk_code[5:4], 2'b10);
    tag = "R3";
    do_req(1, 0, 8'h02, 8'hFF, ack, rd); chk("R3 locked write ack", ack, 1);
    do_req(0, 0, 8'h02, 0, ack, rd); chk("R3 locked byte unchanged", rd, 8'h22);
    do_req(1, 0, 8'h03, 8'h81, ack, rd);
    do_req(0, 0, 8'h03, 0, ack, rd); chk("R2 lock stays set", rd, 8'h81);
    chk("R4 exported code3", blk_code[7:6], 2'b01);
    do_req(1, 0, 8'h08, 8'h01, ack, rd);
    chk("R4 page code", page_code, 2'b01);

    tag = "R8";
    do_req(1, 0, 8'h09, 8'h5A, ack, rd);
    chk("R8 page_wen", page_wen, 8'h5A);
    do_req(1, 0, 8'h0C, 8'h44, ack, rd);
    do_req(0, 0, 8'h0C, 0, ack, rd); chk("R8 byte12", rd, 8'h44);
    for (int i = 0; i < 16; i++) do_req(1, 0, 8'h10 + 8'(i), 8'(i * 37 + 5), ack, rd);
    do_req(0, 0, 8'h13, 0, ack, rd); chk("R8 id byte3", rd, 8'(3 * 37 + 5));

    tag = "R6";
    do_req(1, 0, 8'h0A, 8'h81, ack, rd);
    do_req(0, 0, 8'h0A, 0, ack, rd); chk("R6 enable clears detect", rd, 8'h80);
    do_req(1, 0, 8'h0A, 8'h00, ack, rd);
    do_req(0, 0, 8'h0A, 0, ack, rd); chk("R6 detect stays 0", rd, 8'h00);

    tag = "R7";
    do_req(1, 1, 8'h0B, 8'h00, ack, rd); chk("R7 continued byte nack", ack, 0);
    do_req(0, 0, 8'h0B, 0, ack, rd); chk("R7 no change on nack", rd, 8'hFF);
    do_req(0, 0, 8'h22, 0, ack, rd); chk("R7 high address nack", {ack, rd}, 9'h000);

    tag = "R10";
    @(negedge clk); prot_n = 0;
    do_req(1, 0, 8'h09, 8'h00, ack, rd); chk("R10 nack while protect low", ack, 0);
    @(negedge clk); prot_n = 1;
    chk("R10 R9 page_wen kept", page_wen, 8'h5A);
    tag = "R9";
    do_req(0, 0, 8'h02, 0, ack, rd); chk("R9 R2 byte2 relocked, code kept", rd, 8'hA2);
    do_req(0, 0, 8'h0A, 0, ack, rd); chk("R6 detect reinit", rd, 8'h40);

    tag = "R1";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk);
      req_valid = ($urandom % 4) != 0;
      req_write = $urandom % 2;
      req_cont  = ($urandom % 10) == 0;
      req_addr  = 8'($urandom % 40);
      req_wdata = 8'($urandom);
      if (n % 97 == 50) prot_pulse();
    end
    @(negedge clk); req_valid = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule